// File: doc/BRIEF.md
# Four-Port Memory Request Arbiter with Core Urgency Queue

This block sits in front of one memory module and decides, cycle by cycle, which of four requesting ports gets the module's small buffer memory. It looks at every port in each cycle and accepts at most one of them. Each other port that is requesting gets a reject in that same cycle, and it is free to try again later. A request carries a one-bit fast-access flag. A flagged request beats any request without the flag. When the flags are equal, the port with the lower number wins. The accepted port's address is passed on in the following cycle. An accepted request therefore occupies two cycles and a rejected one occupies a single cycle.

Every accepted request also lands in a small queue of pending core accesses. Each entry in the queue carries a two-bit urgency. Whenever the core can start an access, the queue hands out its most urgent entry, and among entries of equal rank it hands out the oldest. The urgency levels are Low, Warning, Medium and High. A Warning entry ranks the same as a Low one. However, when a new Warning entry arrives, every Warning entry already pending is raised to High.

Top module: `mem_port_arbiter`

## Requirements
- R1: In each cycle at most one port sees `acc_o` high. Every port that has `req_i` high and is not accepted sees `rej_o` high in that same cycle. A port without a request sees neither. Nothing is remembered about a rejected request.
- R2: When any requesting port has `hi_i` set, the accepted port is one of the ports that have `hi_i` set.
- R3: Among requesting ports with the same `hi_i` value, the lowest-numbered port wins. Port 0 ranks highest and port 3 lowest.
- R4: In the cycle after an accept, `xfer_valid_o` is high, and `xfer_port_o` and `xfer_addr_o` give the accepted port's number and address. In the cycle after a cycle with no accept, `xfer_valid_o` is low.
- R5: Each accepted request is added to the core queue, together with its address and its urgency from `urg_i`. The queue entry becomes grantable from the next cycle on.
- R6: When `core_idle_i` is high and the queue is not empty, `core_gnt_o` rises in the same cycle. That entry leaves the queue at the clock edge. Entries rank in this order: High (code 3) first, then Medium (code 2), then Low (code 0) and Warning (code 1), which rank equally.
- R7: Among queued entries of equal rank, the entry that was added first is granted first.
- R8: Accepting a request with Warning urgency (code 1) changes every Warning entry that stays in the queue to High (code 3). The new entry itself stays Warning. `core_urg_o` reports the level as it is stored.
- R9: While the queue holds QDEPTH entries, every request is rejected, even in a cycle where an entry is being granted.
- R10: After reset, and until the first accept, no port is accepted, no transfer is signalled, the queue is empty and no core grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one arbitration cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | NPORTS | Request from each port |
| hi_i | input | NPORTS | Fast-access priority flag from each port |
| urg_i | input | 2*NPORTS | Core urgency for each port, two bits per port, port 0 in the low bits |
| addr_i | input | AW*NPORTS | Address from each port, port 0 in the low bits |
| core_idle_i | input | 1 | Core can start an access in this cycle |
| acc_o | output | NPORTS | Accept indication to each port, same cycle |
| rej_o | output | NPORTS | Reject indication to each port, same cycle |
| xfer_valid_o | output | 1 | Transfer cycle of the previously accepted request |
| xfer_port_o | output | PW | Port number being transferred |
| xfer_addr_o | output | AW | Address being transferred |
| core_gnt_o | output | 1 | A queued entry is granted to core this cycle |
| core_addr_o | output | AW | Address of the granted entry |
| core_urg_o | output | 2 | Stored urgency of the granted entry |

## Verification
The hardest case to reach from the ports is a Warning arrival that promotes older Warning entries while a grant removes another entry in the same cycle. A second hard case is a full queue that keeps rejecting even while it drains. The stimulus reaches both by holding `core_idle_i` low so that entries pile up. It then feeds a directed Low/Warning/Medium/Warning sequence and releases the core. A long random phase follows in which `core_idle_i` is high only about a third of the time. This keeps the queue near full, so grants, Warning arrivals and full-queue rejects overlap often. A behavioural queue model predicts every output on every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    URG_LOW  = 2'd0,
    URG_WARN = 2'd1,
    URG_MED  = 2'd2,
    URG_HIGH = 2'd3
  } urg_e;

  // Competitive rank of a stored urgency: Warning competes as Low.
  function automatic logic [1:0] urg_rank(urg_e u);
    case (u)
      URG_HIGH: urg_rank = 2'd2;
      URG_MED:  urg_rank = 2'd1;
      default:  urg_rank = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_s = stage2_q;
endmodule

// File: rtl/arb_port_pick.sv
module arb_port_pick #(
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              en,
  input  logic [NPORTS-1:0] req,
  input  logic [NPORTS-1:0] hi,
  output logic [NPORTS-1:0] acc,
  output logic [PW-1:0]     win,
  output logic              any
);
  logic [NPORTS-1:0] pool;
  logic [NPORTS-1:0] onehot;

  // Flagged requests form the pool when present; otherwise all requests.
  always_comb begin
    pool = ((req & hi) != '0) ? (req & hi) : req;
  end

  // Lowest index in the pool wins: scan from the top down.
  always_comb begin
    win    = '0;
    onehot = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (pool[i]) begin
        win    = PW'(i);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
  end

  assign any = en && (req != '0);
  assign acc = any ? onehot : '0;
endmodule

// File: rtl/arb_core_queue.sv
module arb_core_queue
  import arb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 14,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  urg_e          push_urg,
  input  logic          core_idle,
  output logic          gnt,
  output logic [AW-1:0] gnt_addr,
  output urg_e          gnt_urg,
  output logic [CW-1:0] count
);
  logic [AW-1:0] q_addr [DEPTH];
  urg_e          q_urg  [DEPTH];
  logic [CW-1:0] cnt_q;

  logic [AW-1:0] n_addr [DEPTH];
  urg_e          n_urg  [DEPTH];
  logic [CW-1:0] cnt_base;
  logic [CW-1:0] cnt_d;
  logic [IW-1:0] sel;
  logic [1:0]    best;
  logic          upd;

  // Entries are kept compacted: index 0 is the oldest.
  // Scan down so the lowest index of the highest rank is left in sel.
  always_comb begin
    sel  = '0;
    best = 2'd0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CW'(i) < cnt_q && urg_rank(q_urg[i]) >= best) begin
        sel  = IW'(i);
        best = urg_rank(q_urg[i]);
      end
    end
  end

  assign gnt      = core_idle && (cnt_q != '0);
  assign gnt_addr = q_addr[sel];
  assign gnt_urg  = q_urg[sel];
  assign cnt_base = cnt_q - CW'(gnt);

  // Next state: close the gap left by a grant, promote, then append.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (gnt && IW'(i) >= sel && i < DEPTH - 1) begin
        n_addr[i] = q_addr[(i < DEPTH - 1) ? i + 1 : i];
        n_urg[i]  = q_urg[(i < DEPTH - 1) ? i + 1 : i];
      end else begin
        n_addr[i] = q_addr[i];
        n_urg[i]  = q_urg[i];
      end
      if (push && push_urg == URG_WARN && n_urg[i] == URG_WARN) begin
        n_urg[i] = URG_HIGH;
      end
    end
    if (push && cnt_base < CW'(DEPTH)) begin
      n_addr[IW'(cnt_base)] = push_addr;
      n_urg[IW'(cnt_base)]  = push_urg;
    end
    cnt_d = cnt_base + CW'(push);
  end

  assign upd = gnt || push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      q_addr <= n_addr;
      q_urg  <= n_urg;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
  import arb_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int AW     = 14,
  parameter int QDEPTH = 8,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    req_i,
  input  logic [NPORTS-1:0]    hi_i,
  input  logic [2*NPORTS-1:0]  urg_i,
  input  logic [AW*NPORTS-1:0] addr_i,
  input  logic                 core_idle_i,
  output logic [NPORTS-1:0]    acc_o,
  output logic [NPORTS-1:0]    rej_o,
  output logic                 xfer_valid_o,
  output logic [PW-1:0]        xfer_port_o,
  output logic [AW-1:0]        xfer_addr_o,
  output logic                 core_gnt_o,
  output logic [AW-1:0]        core_addr_o,
  output logic [1:0]           core_urg_o
);
  logic          rst_s;
  logic          pick_en;
  logic          any_acc;
  logic [PW-1:0] win;
  logic [AW-1:0] win_addr;
  urg_e          win_urg;
  logic [CW-1:0] q_cnt;
  urg_e          gnt_urg;

  logic          xv_q, xv_d;
  logic [PW-1:0] xp_q;
  logic [AW-1:0] xa_q;

  arb_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  assign pick_en = rst_s && (q_cnt != CW'(QDEPTH));

  arb_port_pick #(.NPORTS(NPORTS)) u_pick (
    .en  (pick_en),
    .req (req_i),
    .hi  (hi_i),
    .acc (acc_o),
    .win (win),
    .any (any_acc)
  );

  assign rej_o    = req_i & ~acc_o;
  assign win_addr = addr_i[win*AW +: AW];
  assign win_urg  = urg_e'(urg_i[win*2 +: 2]);

  arb_core_queue #(.DEPTH(QDEPTH), .AW(AW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_s),
    .push      (any_acc),
    .push_addr (win_addr),
    .push_urg  (win_urg),
    .core_idle (core_idle_i),
    .gnt       (core_gnt_o),
    .gnt_addr  (core_addr_o),
    .gnt_urg   (gnt_urg),
    .count     (q_cnt)
  );

  assign core_urg_o = gnt_urg;

  // Transfer stage: one cycle behind the accept.
  always_comb begin
    xv_d = any_acc;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      xv_q <= 1'b0;
    end else begin
      xv_q <= xv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (any_acc) begin
      xp_q <= win;
      xa_q <= win_addr;
    end
  end

  assign xfer_valid_o = xv_q;
  assign xfer_port_o  = xp_q;
  assign xfer_addr_o  = xa_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NPORTS = 4,
  parameter int QDEPTH = 8,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input logic              clk,
  input logic              rst_s,
  input logic [NPORTS-1:0] req_i,
  input logic [NPORTS-1:0] hi_i,
  input logic [NPORTS-1:0] acc_o,
  input logic [NPORTS-1:0] rej_o,
  input logic              xfer_valid_o,
  input logic              core_gnt_o,
  input logic              core_idle_i,
  input logic [CW-1:0]     q_cnt
);
  assert_single_accept_R1: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(acc_o));

  assert_reply_cover_R1: assert property (@(posedge clk) disable iff (!rst_s)
    ((acc_o | rej_o) == req_i) && ((acc_o & rej_o) == '0));

  assert_flag_wins_R2: assert property (@(posedge clk) disable iff (!rst_s)
    ((acc_o != '0) && ((req_i & hi_i) != '0)) |-> ((acc_o & hi_i) != '0));

  assert_port0_rank_R3: assert property (@(posedge clk) disable iff (!rst_s)
    ((acc_o != '0) && req_i[0] && (hi_i[0] || ((req_i & hi_i) == '0))) |-> acc_o[0]);

  assert_xfer_follows_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (acc_o != '0) |=> xfer_valid_o);

  assert_xfer_quiet_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (acc_o == '0) |=> !xfer_valid_o);

  assert_enqueue_R5: assert property (@(posedge clk) disable iff (!rst_s)
    ((acc_o != '0) && !core_gnt_o) |=> (q_cnt == $past(q_cnt) + CW'(1)));

  assert_grant_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_s)
    core_gnt_o |-> (core_idle_i && q_cnt != '0));

  assert_full_rejects_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (q_cnt == CW'(QDEPTH)) |-> (acc_o == '0));
endmodule

bind mem_port_arbiter arb_checker #(.NPORTS(NPORTS), .QDEPTH(QDEPTH)) u_chk (
  .clk          (clk),
  .rst_s        (rst_s),
  .req_i        (req_i),
  .hi_i         (hi_i),
  .acc_o        (acc_o),
  .rej_o        (rej_o),
  .xfer_valid_o (xfer_valid_o),
  .core_gnt_o   (core_gnt_o),
  .core_idle_i  (core_idle_i),
  .q_cnt        (q_cnt)
);

// File: tb/mem_port_arbiter_test.sv
module mem_port_arbiter_test;
  localparam int N  = 4;
  localparam int AW = 14;
  localparam int QD = 8;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req_i;
  logic [N-1:0]    hi_i;
  logic [2*N-1:0]  urg_i;
  logic [AW*N-1:0] addr_i;
  logic            core_idle_i;
  logic [N-1:0]    acc_o;
  logic [N-1:0]    rej_o;
  logic            xfer_valid_o;
  logic [1:0]      xfer_port_o;
  logic [AW-1:0]   xfer_addr_o;
  logic            core_gnt_o;
  logic [AW-1:0]   core_addr_o;
  logic [1:0]      core_urg_o;

  mem_port_arbiter #(.NPORTS(N), .AW(AW), .QDEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .hi_i(hi_i), .urg_i(urg_i),
    .addr_i(addr_i), .core_idle_i(core_idle_i), .acc_o(acc_o), .rej_o(rej_o),
    .xfer_valid_o(xfer_valid_o), .xfer_port_o(xfer_port_o),
    .xfer_addr_o(xfer_addr_o), .core_gnt_o(core_gnt_o),
    .core_addr_o(core_addr_o), .core_urg_o(core_urg_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state
  int m_addr[$];
  int m_urg[$];
  bit prev_v   = 0;
  int prev_p   = 0;
  int prev_a   = 0;

  function automatic int rank_of(int u);
    return (u == 3) ? 2 : (u == 2) ? 1 : 0;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] hp,
                      input logic [2*N-1:0] ug, input logic [AW*N-1:0] ad,
                      input logic idle);
    int  ea;
    int  win;
    bit  full;
    int  best;
    int  gi;
    @(negedge clk);
    req_i = rq; hi_i = hp; urg_i = ug; addr_i = ad; core_idle_i = idle;
    #1;
    full = (m_addr.size() == QD);
    ea = 0; win = -1;
    if (!full && rq != 0) begin
      logic [N-1:0] pool;
      pool = ((rq & hp) != 0) ? (rq & hp) : rq;
      for (int p = N - 1; p >= 0; p--) if (pool[p]) win = p;
      ea = 1 << win;
    end
    if (full)
      check(acc_o == 0 && rej_o == rq, "R9 full queue rejects", {acc_o, rej_o}, {4'h0, rq});
    else
      check(acc_o == 4'(ea), "R1 R2 R3 accept", acc_o, ea);
    check(rej_o == (rq & ~4'(ea)), "R1 reject", rej_o, rq & ~4'(ea));
    check(xfer_valid_o == prev_v, "R4 xfer valid", xfer_valid_o, prev_v);
    if (prev_v)
      check(xfer_port_o == 2'(prev_p) && xfer_addr_o == AW'(prev_a),
            "R4 xfer port/addr", {xfer_port_o, xfer_addr_o}, {2'(prev_p), AW'(prev_a)});
    gi = -1;
    if (idle && m_addr.size() > 0) begin
      best = -1;
      foreach (m_urg[k]) if (rank_of(m_urg[k]) > best) begin best = rank_of(m_urg[k]); gi = k; end
    end
    check(core_gnt_o == (gi >= 0), "R6 grant present", core_gnt_o, gi >= 0);
    if (gi >= 0)
      check(core_addr_o == AW'(m_addr[gi]) && core_urg_o == 2'(m_urg[gi]),
            "R5 R6 R7 R8 granted entry", {core_urg_o, core_addr_o},
            {2'(m_urg[gi]), AW'(m_addr[gi])});
    // advance model
    if (gi >= 0) begin m_addr.delete(gi); m_urg.delete(gi); end
    if (win >= 0) begin
      int nu;
      nu = int'(ug[win*2 +: 2]);
      if (nu == 1) foreach (m_urg[k]) if (m_urg[k] == 1) m_urg[k] = 3;
      m_addr.push_back(int'(ad[win*AW +: AW]));
      m_urg.push_back(nu);
      prev_p = win; prev_a = int'(ad[win*AW +: AW]);
    end
    prev_v = (win >= 0);
  endtask

  function automatic logic [AW*N-1:0] one_addr(int port, int a);
    logic [AW*N-1:0] v;
    v = '0;
    v[port*AW +: AW] = AW'(a);
    return v;
  endfunction

  initial begin
    rst_n = 1'b0; req_i = '0; hi_i = '0; urg_i = '0; addr_i = '0; core_idle_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step('0, '0, '0, '0, 1'b0);
    // R10: reset state, empty queue with the core idle
    step('0, '0, '0, '0, 1'b1);
    check(acc_o == 0 && !xfer_valid_o && !core_gnt_o, "R10 reset state",
          {acc_o, xfer_valid_o, core_gnt_o}, 0);
    // R3: all ports request, port 0 wins
    step(4'hF, 4'h0, 8'h00, {14'd3, 14'd2, 14'd1, 14'd100}, 1'b0);
    // R2: flagged port 2 beats port 1
    step(4'h6, 4'h4, 8'h00, {14'd0, 14'd200, 14'd7, 14'd0}, 1'b0);
    // R1: lone port 3, then R4 transfer
    step(4'h8, 4'h0, 8'h00, {14'd300, 14'd0, 14'd0, 14'd0}, 1'b0);
    step('0, '0, '0, '0, 1'b0);
    // drain
    repeat (5) step('0, '0, '0, '0, 1'b1);
    check(m_addr.size() == 0 && !core_gnt_o, "R6 drained", core_gnt_o, 0);
    // R8 R7: L, W, M, W then drain -> W(H), M, L, W
    step(4'h1, 4'h0, 8'h00, one_addr(0, 16), 1'b0);
    step(4'h1, 4'h0, 8'h01, one_addr(0, 17), 1'b0);
    step(4'h1, 4'h0, 8'h02, one_addr(0, 18), 1'b0);
    step(4'h1, 4'h0, 8'h01, one_addr(0, 19), 1'b0);
    step('0, '0, '0, '0, 1'b1);
    check(core_addr_o == 14'd17 && core_urg_o == 2'd3, "R8 promoted first",
          {core_urg_o, core_addr_o}, {2'd3, 14'd17});
    step('0, '0, '0, '0, 1'b1);
    step('0, '0, '0, '0, 1'b1);
    check(core_addr_o == 14'd16, "R7 oldest of Low/Warning tie", core_addr_o, 16);
    step('0, '0, '0, '0, 1'b1);
    check(core_addr_o == 14'd19 && core_urg_o == 2'd1, "R8 newest stays Warning",
          {core_urg_o, core_addr_o}, {2'd1, 14'd19});
    // R9: fill, then request while full, also while draining
    for (int i = 0; i < QD; i++) step(4'h2, 4'h0, 8'h00, one_addr(1, 40 + i), 1'b0);
    step(4'h3, 4'h1, 8'h00, one_addr(0, 99), 1'b0);
    check(acc_o == 0 && rej_o == 4'h3, "R9 reject when full", acc_o, 0);
    step(4'h3, 4'h0, 8'h00, one_addr(0, 98), 1'b1);
    check(acc_o == 0 && core_gnt_o, "R9 reject while draining", {acc_o, core_gnt_o}, 1);
    // random phase
    for (int c = 0; c < 6000; c++) begin
      logic [AW*N-1:0] ad;
      for (int p = 0; p < N; p++) ad[p*AW +: AW] = AW'($urandom);
      step(4'($urandom), 4'($urandom) & 4'($urandom), 8'($urandom), ad,
           ($urandom % 3) == 0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule